// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-clock, synthesizable on-chip memory that behaves like a pipelined synchronous burst SRAM. Every control, address and data input is captured on the rising clock edge. Read data leaves through an output register. A 2-bit burst counter produces the three words that follow a starting address. The counter can walk the four-word group either in interleaved order or in linear order.

A cycle starts when either of two active-low address strobes is seen. The processor strobe is ignored while the primary chip enable is high. The controller strobe is always taken. After a strobe, the advance input steps through the burst. A cycle with no strobe and no advance repeats the current address. Writes are self-timed. A global write stores every byte lane. Otherwise, a byte-write enable together with per-lane strobes stores only the selected lanes.

The output drive indication is removed at once, without waiting for a clock, when output enable is released or sleep is raised. The pad driver uses `drive_o` to decide when to drive the bus. While sleep is high, the block ignores new cycles and keeps the array contents.

Top module: `burst_sram`

## Requirements
- R1: The address is captured on a rising edge when `cstb_n_i` is low, or when `pstb_n_i` is low while `sel0_n_i` is low. A processor strobe seen while `sel0_n_i` is high has no effect: access continues at the current burst address.
- R2: The chip is selected only if `sel0_n_i`=0, `sel1_i`=1 and `sel2_n_i`=0 are all sampled under a strobe. Any other combination makes the cycle a deselect.
- R3: Read data for a strobed read appears on `rdata_o`, with `drive_o` high, after the second rising edge counted from the edge that sampled the strobe. Each advance cycle after that delivers the next word one edge later (3-1-1-1).
- R4: The 2-bit count advances only in cycles where `step_n_i` is low. A cycle with no strobe and `step_n_i` high accesses the same address again.
- R5: With `linear_i`=0 sampled at the strobe, the low two address bits of burst word k are the start offset XOR k.
- R6: With `linear_i`=1 sampled at the strobe, the low two address bits of burst word k are (start offset + k) mod 4. The upper address bits stay fixed.
- R7: When `all_wr_n_i`=0, all four byte lanes of the cycle's address are written with `wdata_i`, whatever the other write inputs are.
- R8: When `all_wr_n_i`=1 and `lane_wr_n_i`=0, exactly the lanes with `lane_n_i[b]`=0 are written, where lane b is `wdata_i[8b+7:8b]`. With both write inputs high, the cycle is a read.
- R9: A write cycle never raises `drive_o` for its output slot.
- R10: `drive_o` falls in the same cycle that `oe_n_i` goes high, with no clock edge needed.
- R11: A strobed cycle that samples the chip as deselected leaves `drive_o` low in its output slot, one cycle after the next edge.
- R12: While `sleep_i`=1, `drive_o` is low, strobes and writes are ignored, and the array contents are kept. After sleep is released, no access takes place until the next strobe.
- R13: After reset, `drive_o` is low until the first selected read has come through the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the control pipeline |
| addr_i | input | AW | Word address |
| wdata_i | input | 8*NB | Write data, NB byte lanes |
| sel0_n_i | input | 1 | Primary chip enable, active low |
| sel1_i | input | 1 | Second chip enable, active high |
| sel2_n_i | input | 1 | Third chip enable, active low |
| pstb_n_i | input | 1 | Processor address strobe, active low |
| cstb_n_i | input | 1 | Controller address strobe, active low |
| step_n_i | input | 1 | Burst advance, active low |
| lane_wr_n_i | input | 1 | Byte-write enable, active low |
| lane_n_i | input | NB | Per-lane write strobes, active low |
| all_wr_n_i | input | 1 | Global write, active low |
| linear_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep request, active high |
| rdata_o | output | 8*NB | Registered read data |
| drive_o | output | 1 | High when the data bus must be driven |

## Verification
A wrong burst count or a wrong order flag shows up as a wrong word on `rdata_o` on the cycle right after the faulty advance. A lost chip-select or write flag shows up as a `drive_o` value that is wrong two edges after the strobe. Lane-mask faults stay in the array until the address is read again, so the bench reads back every written word. It also reads the array again after sleep and after ignored processor strobes.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr_i,
  input  logic [8*NB-1:0] wdata_i,
  input  logic            sel0_n_i,
  input  logic            sel1_i,
  input  logic            sel2_n_i,
  input  logic            pstb_n_i,
  input  logic            cstb_n_i,
  input  logic            step_n_i,
  input  logic            lane_wr_n_i,
  input  logic [NB-1:0]   lane_n_i,
  input  logic            all_wr_n_i,
  input  logic            linear_i,
  input  logic            oe_n_i,
  input  logic            sleep_i,
  output logic [8*NB-1:0] rdata_o,
  output logic            drive_o
);
  localparam int DW    = 8 * NB;
  localparam int WORDS = 2 ** AW;

  logic [DW-1:0] mem [WORDS];

  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic          sel_q, lin_q;

  logic          acc_q, wr_q;
  logic [AW-1:0] acc_a_q;
  logic [NB-1:0] be_q;
  logic [DW-1:0] wd_q;

  logic          rd_v_q;
  logic [DW-1:0] rd_q;

  logic          strobe, chip_on, step;
  logic [1:0]    nxt_cnt, nxt_off;
  logic [AW-1:0] cyc_addr;
  logic          cyc_sel;
  logic [NB-1:0] be;

  assign strobe  = !cstb_n_i || (!pstb_n_i && !sel0_n_i);
  assign chip_on = !sel0_n_i && sel1_i && !sel2_n_i;
  assign step    = !step_n_i;
  assign nxt_cnt = step ? cnt_q + 2'd1 : cnt_q;
  assign nxt_off = lin_q ? base_q[1:0] + nxt_cnt : base_q[1:0] ^ nxt_cnt;

  assign cyc_addr = strobe ? addr_i : {base_q[AW-1:2], nxt_off};
  assign cyc_sel  = strobe ? chip_on : sel_q;
  assign be       = !all_wr_n_i  ? {NB{1'b1}} :
                    !lane_wr_n_i ? ~lane_n_i  : {NB{1'b0}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      acc_q  <= 1'b0;
      rd_v_q <= 1'b0;
    end else begin
      rd_v_q <= acc_q && !wr_q;
      if (sleep_i) begin
        sel_q <= 1'b0;
        acc_q <= 1'b0;
      end else begin
        acc_q <= cyc_sel;
        if (strobe) sel_q <= chip_on;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!sleep_i) begin
      if (strobe) begin
        base_q <= addr_i;
        cnt_q  <= 2'd0;
        lin_q  <= linear_i;
      end else begin
        cnt_q <= nxt_cnt;
      end
      acc_a_q <= cyc_addr;
      be_q    <= be;
      wr_q    <= |be;
      wd_q    <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    rd_q <= mem[acc_a_q];
    for (int b = 0; b < NB; b++)
      if (acc_q && be_q[b]) mem[acc_a_q][8*b +: 8] <= wd_q[8*b +: 8];
  end

  assign rdata_o = rd_q;
  assign drive_o = rd_v_q && !oe_n_i && !sleep_i;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic sel0_n_i,
  input logic sel1_i,
  input logic sel2_n_i,
  input logic cstb_n_i,
  input logic lane_wr_n_i,
  input logic all_wr_n_i,
  input logic oe_n_i,
  input logic sleep_i,
  input logic drive_o
);
  logic on;
  assign on = !sel0_n_i && sel1_i && !sel2_n_i;

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cstb_n_i && !sleep_i && !on) |=> ##1 !drive_o); // R11
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cstb_n_i && !sleep_i && on && !all_wr_n_i) |=> ##1 !drive_o); // R9
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cstb_n_i && !sleep_i && on && all_wr_n_i && lane_wr_n_i) |=> ##1 (oe_n_i || sleep_i || drive_o)); // R3
  AST_OE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> !drive_o); // R10
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> !drive_o); // R12
endmodule

bind burst_sram burst_sram_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sel0_n_i(sel0_n_i), .sel1_i(sel1_i),
  .sel2_n_i(sel2_n_i), .cstb_n_i(cstb_n_i), .lane_wr_n_i(lane_wr_n_i),
  .all_wr_n_i(all_wr_n_i), .oe_n_i(oe_n_i), .sleep_i(sleep_i), .drive_o(drive_o)
);

// File: tb/burst_sram_tb.sv
`timescale 1ns/1ps
module burst_sram_tb_top;
  localparam int AW = 6;
  localparam int NB = 4;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = 0;
  logic [31:0] wdata = 0;
  logic sel0_n = 0, sel1 = 1, sel2_n = 0, pstb_n = 1, cstb_n = 1, step_n = 1;
  logic lane_wr_n = 1, all_wr_n = 1, linear = 0, oe_n = 0, sleep = 0;
  logic [NB-1:0] lane_n = '1;
  logic [31:0] rdata;
  logic drive;

  burst_sram #(.AW(AW), .NB(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
    .sel0_n_i(sel0_n), .sel1_i(sel1), .sel2_n_i(sel2_n),
    .pstb_n_i(pstb_n), .cstb_n_i(cstb_n), .step_n_i(step_n),
    .lane_wr_n_i(lane_wr_n), .lane_n_i(lane_n), .all_wr_n_i(all_wr_n),
    .linear_i(linear), .oe_n_i(oe_n), .sleep_i(sleep),
    .rdata_o(rdata), .drive_o(drive));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R13";

  logic [31:0] mm [64];
  logic [AW-1:0] m_base; logic [1:0] m_cnt; logic m_sel = 0, m_lin = 0;
  logic p_v = 0, p_w = 0; logic [AW-1:0] p_a = 0; logic [3:0] p_be = 0; logic [31:0] p_d = 0;
  logic o_v = 0; logic [31:0] o_d = 0;

  function automatic logic [1:0] boff(logic [1:0] st, logic [1:0] c, logic lin);
    return lin ? st + c : st ^ c;
  endfunction

  task automatic model_step();
    logic nv; logic [31:0] nd; logic stb, on; logic [1:0] nc; logic [3:0] be;
    nv = p_v && !p_w; nd = mm[p_a];
    if (p_v) for (int b = 0; b < 4; b++) if (p_be[b]) mm[p_a][8*b +: 8] = p_d[8*b +: 8];
    if (sleep) begin
      p_v = 0; m_sel = 0;
    end else begin
      stb = !cstb_n || (!pstb_n && !sel0_n);
      on  = !sel0_n && sel1 && !sel2_n;
      be  = !all_wr_n ? 4'hF : (!lane_wr_n ? ~lane_n : 4'h0);
      if (stb) begin
        p_a = addr; m_base = addr; m_cnt = 0; m_lin = linear; m_sel = on; p_v = on;
      end else begin
        nc = step_n ? m_cnt : m_cnt + 2'd1;
        m_cnt = nc;
        p_a = {m_base[AW-1:2], boff(m_base[1:0], nc, m_lin)};
        p_v = m_sel;
      end
      p_be = be; p_w = |be; p_d = wdata;
    end
    o_v = nv; o_d = nd;
  endtask

  task automatic check_out();
    logic exp_en;
    exp_en = o_v && !oe_n && !sleep;
    checks++;
    if (drive !== exp_en) begin
      fails++;
      $display("FAIL %s drive_o act=%0b exp=%0b", tag, drive, exp_en);
    end else if (exp_en && rdata !== o_d) begin
      fails++;
      $display("FAIL %s rdata_o act=%h exp=%h", tag, rdata, o_d);
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check_out();
  endtask

  task automatic idle();
    pstb_n = 1; cstb_n = 1; step_n = 1; all_wr_n = 1; lane_wr_n = 1; lane_n = '1;
    sel0_n = 0; sel1 = 1; sel2_n = 0; oe_n = 0; sleep = 0;
  endtask

  task automatic burst(logic [AW-1:0] a, logic lin, bit use_p);
    idle(); addr = a; linear = lin;
    if (use_p) pstb_n = 0; else cstb_n = 0;
    tick();
    idle(); step_n = 1; tick();
    step_n = 0; tick(); tick(); tick();
    idle(); tick();
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    checks++;
    if (drive !== 1'b0) begin fails++; $display("FAIL R13 drive_o act=%0b exp=0", drive); end
    rst_n = 1;
    @(negedge clk);
    tag = "R13"; idle(); tick();

    tag = "R9";
    for (int a = 0; a < 64; a++) begin
      idle(); cstb_n = 0; addr = a[AW-1:0]; all_wr_n = 0; wdata = $urandom; tick();
    end
    idle(); tick(); tick();

    tag = "R7";
    for (int a = 0; a < 64; a += 9) begin
      idle(); cstb_n = 0; addr = a[AW-1:0]; tick(); idle(); tick();
    end
    idle(); cstb_n = 0; addr = 6'd5; all_wr_n = 0; lane_wr_n = 0; lane_n = 4'b0111;
    wdata = 32'hA5A5_5A5A; tick(); idle(); tick();
    cstb_n = 0; tick(); idle(); tick();

    tag = "R3";  burst(6'd16, 0, 1);
    tag = "R5";  burst(6'd22, 0, 0);
    tag = "R6";  burst(6'd27, 1, 0);
    tag = "R6";  burst(6'd33, 1, 1);

    tag = "R4";
    idle(); cstb_n = 0; addr = 6'd41; tick(); idle(); tick(); tick(); tick();
    step_n = 0; tick(); step_n = 1; tick(); tick();

    tag = "R8";
    idle(); cstb_n = 0; addr = 6'd9; lane_wr_n = 0; lane_n = 4'b1010; wdata = 32'h1122_3344; tick();
    idle(); tick(); cstb_n = 0; tick(); idle(); tick();
    cstb_n = 0; lane_wr_n = 1; lane_n = 4'b0000; wdata = 32'hFFFF_FFFF; tick();
    idle(); tick(); cstb_n = 0; tick(); idle(); tick();

    tag = "R1";
    idle(); cstb_n = 0; addr = 6'd50; tick(); idle(); tick();
    pstb_n = 0; sel0_n = 1; addr = 6'd3; tick(); tick();
    idle(); tick(); tick();

    tag = "R2";
    idle(); cstb_n = 0; addr = 6'd12; sel1 = 0; tick(); idle(); tick(); tick();
    cstb_n = 0; sel2_n = 1; tick(); idle(); tick(); tick();
    cstb_n = 0; sel0_n = 1; tick(); idle(); tick(); tick();

    tag = "R11";
    idle(); cstb_n = 0; addr = 6'd14; tick();
    cstb_n = 0; sel1 = 0; tick(); idle(); tick(); tick();

    tag = "R10";
    idle(); cstb_n = 0; addr = 6'd20; tick(); idle(); tick();
    oe_n = 1; #1;
    checks++;
    if (drive !== 1'b0) begin fails++; $display("FAIL R10 drive_o act=%0b exp=0", drive); end
    oe_n = 0; #1;
    checks++;
    if (drive !== 1'b1) begin fails++; $display("FAIL R10 drive_o act=%0b exp=1", drive); end
    @(negedge clk); tick();

    tag = "R12";
    idle(); cstb_n = 0; addr = 6'd30; tick(); idle(); tick();
    sleep = 1; #1;
    checks++;
    if (drive !== 1'b0) begin fails++; $display("FAIL R12 drive_o act=%0b exp=0", drive); end
    @(negedge clk);
    cstb_n = 0; addr = 6'd30; all_wr_n = 0; wdata = 32'hDEAD_BEEF; tick();
    cstb_n = 1; all_wr_n = 1; tick(); tick();
    idle(); tick(); tick();
    cstb_n = 0; addr = 6'd30; tick(); idle(); tick();

    tag = "R3";
    for (int i = 0; i < 3000; i++) begin
      cstb_n    = ($urandom % 10) >= 3;
      pstb_n    = ($urandom % 10) >= 2;
      sel0_n    = ($urandom % 100) >= 85;
      sel1      = ($urandom % 10) != 0;
      sel2_n    = ($urandom % 10) == 0;
      step_n    = $urandom % 2;
      all_wr_n  = ($urandom % 10) != 0;
      lane_wr_n = ($urandom % 100) >= 15;
      lane_n    = $urandom;
      linear    = $urandom % 2;
      oe_n      = ($urandom % 10) == 0;
      sleep     = ($urandom % 20) == 0;
      addr      = $urandom;
      wdata     = $urandom;
      tick();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule